// File: doc/BRIEF.md
# Ternary Row Write-and-Verify Sequencer

This block stores one ternary word into a single row of a resistive ternary match array. The array has no separate write port: each cell holds two programmable elements, a left one and a middle one. A column is reached by raising its select line, and the row is written by firing a program strobe with the target level. The sequencer turns a request (row, data, wildcard mask) into a fixed order of program steps. Every element that must become low is written first. The left elements that must become high come next, then the middle elements that must become high. Each step is cut into column segments, so the number of elements driven at once stays bounded.

After programming, the sequencer checks the row through the search path. It clears every row enable and enables only the written row. It then runs two full-row searches: one with wildcards replaced by ones, one with wildcards replaced by zeros. Last, it runs a single-column search for every non-wildcard cell, using the complement of the stored bit, which must miss. Any failure ends the operation with an error.

Requests arrive on a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. A requester facing a low `req_ready` keeps its request pending, and the block never samples it. The array side and the status pins are plain signals. `WIDTH` must be a multiple of `SEG_W`, and `SEG_W` must not exceed 128.

Top module: `trow_wv_seq`

## Requirements
- R1: Cell encoding after a successful write: a 1 leaves left high and middle low, a 0 leaves left low and middle high, and a wildcard (mask bit 1) leaves both high.
- R2: While `prog_en` is high, `srch_en` is low and every `srch_wild` line is low.
- R3: The low step (`prog_lvl`=0) comes first and selects left for 0-cells and middle for 1-cells. The left-high step follows and selects left for 1-cells and wildcard cells. The middle-high step comes last and selects middle for 0-cells and wildcard cells. No select line is high without `prog_en`.
- R4: Each step runs once per segment of `SEG_W` columns (segment 0 first) and holds `prog_en` for `PROG_CYCLES` cycles. At most `SEG_W` selects are high at once, so a write takes 3·(`WIDTH`/`SEG_W`)·`PROG_CYCLES` strobe cycles.
- R5: After programming, one cycle pulses `en_clr_all` and `en_set` on `arr_row`, leaving only that row enabled. Two full searches with no wildcard lines follow: key = data|mask, then key = data&~mask. `srch_hit` is sampled one cycle after issue, and a miss on either search sets `err`.
- R6: Each non-wildcard cell is then searched alone, in rising column order, with key bit = complement of its data bit and all other wildcard lines high. A hit sets `err` and stops the operation. Wildcard cells are skipped, so a successful write issues 2 + (number of non-wildcard cells) searches.
- R7: `done` is high for exactly one cycle at the end of each operation, success or failure, and `busy` is low in that cycle. `err` stays at its value until the next accepted request clears it.
- R8: `req_ready` equals not `busy`. A `req_valid` raised while busy has no effect on the array or on the outputs.
- R9: After reset, `busy`, `done`, `err`, `prog_en`, `srch_en` and the enable strobes are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request can be taken (idle) |
| req_row | input | ROW_W | Target row index |
| req_data | input | WIDTH | Data bits |
| req_mask | input | WIDTH | Wildcard mask, 1 = wildcard |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Verification failed on last operation |
| arr_row | output | ROW_W | Row addressed by program strobe and enable set |
| prog_en | output | 1 | Row program strobe |
| prog_lvl | output | 1 | Level programmed: 1 high, 0 low |
| sel_left | output | WIDTH | Per-column left element select |
| sel_mid | output | WIDTH | Per-column middle element select |
| en_clr_all | output | 1 | Clear all row enables |
| en_set | output | 1 | Set enable of `arr_row` |
| srch_en | output | 1 | Search issue (match sense enabled) |
| srch_key | output | WIDTH | Search key bits |
| srch_wild | output | WIDTH | Per-column wildcard search lines |
| srch_hit | input | 1 | Match result, valid the cycle after issue |

## Verification
The bench uses an array model that can lose a low write on one column, which makes that cell an unintended wildcard. A design without the single-cell pass would report success there. The model can also lose a left-high write on a cell that held a 0, which leaves a cell matching nothing. A design that skips the full-row searches would miss that fault. The bench collects every select asserted in each step, so a wrong phase order, a merged step or a wrong encoding shows up as a select set that differs. It also covers an all-wildcard word, where every cell check must be skipped, and a request raised while busy, which a design without the ready gate would latch onto another row.

// File: rtl/twv_pkg.sv
package twv_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOW, ST_HIL, ST_HIM, ST_ENA,
    ST_S1, ST_W1, ST_S2, ST_W2, ST_CELL, ST_CW
  } twv_state_e;

  typedef enum logic [1:0] {PH_NONE, PH_LOW, PH_HIL, PH_HIM} twv_phase_e;

  typedef enum logic [1:0] {VK_NONE, VK_ONES, VK_ZEROS, VK_CELL} twv_vkind_e;
endpackage

// File: rtl/twv_sel_gen.sv
module twv_sel_gen
  import twv_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SEG_W = 8,
  localparam int NSEG = WIDTH / SEG_W,
  localparam int SEG_IW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  twv_phase_e        phase,
  input  logic [SEG_IW-1:0] seg,
  input  logic [WIDTH-1:0]  data,
  input  logic [WIDTH-1:0]  mask,
  output logic [WIDTH-1:0]  sel_left,
  output logic [WIDTH-1:0]  sel_mid
);
  logic [WIDTH-1:0] want_l, want_m, segmask;

  // one window of SEG_W columns is open per step
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign segmask[g*SEG_W +: SEG_W] = {SEG_W{seg == SEG_IW'(g)}};
  end

  always_comb begin
    want_l = '0;
    want_m = '0;
    case (phase)
      PH_LOW: begin
        want_l = ~data & ~mask;
        want_m = data & ~mask;
      end
      PH_HIL: want_l = data | mask;
      PH_HIM: want_m = ~data | mask;
      default: ;
    endcase
  end

  assign sel_left = want_l & segmask;
  assign sel_mid  = want_m & segmask;
endmodule

// File: rtl/twv_key_gen.sv
module twv_key_gen
  import twv_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int COL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  twv_vkind_e       kind,
  input  logic [COL_W-1:0] col,
  input  logic [WIDTH-1:0] data,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] key,
  output logic [WIDTH-1:0] wild
);
  logic [WIDTH-1:0] col_hot;

  for (genvar c = 0; c < WIDTH; c++) begin : g_hot
    assign col_hot[c] = (col == COL_W'(c));
  end

  always_comb begin
    key  = '0;
    wild = '0;
    case (kind)
      VK_ONES:  key = data | mask;
      VK_ZEROS: key = data & ~mask;
      VK_CELL: begin
        key  = ~data & col_hot;
        wild = ~col_hot;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trow_wv_seq.sv
module trow_wv_seq
  import twv_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int WIDTH = 16,
  parameter int SEG_W = 8,
  parameter int PROG_CYCLES = 3,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [WIDTH-1:0] req_data,
  input  logic [WIDTH-1:0] req_mask,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [ROW_W-1:0] arr_row,
  output logic             prog_en,
  output logic             prog_lvl,
  output logic [WIDTH-1:0] sel_left,
  output logic [WIDTH-1:0] sel_mid,
  output logic             en_clr_all,
  output logic             en_set,
  output logic             srch_en,
  output logic [WIDTH-1:0] srch_key,
  output logic [WIDTH-1:0] srch_wild,
  input  logic             srch_hit
);
  localparam int NSEG   = WIDTH / SEG_W;
  localparam int SEG_IW = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam int COL_W  = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int PC_W   = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

  twv_state_e        state;
  logic [ROW_W-1:0]  row_q;
  logic [WIDTH-1:0]  data_q, mask_q;
  logic [SEG_IW-1:0] seg_q;
  logic [PC_W-1:0]   cyc_q;
  logic [COL_W-1:0]  col_q;
  logic              done_q, err_q;

  twv_phase_e phase;
  twv_vkind_e vkind;
  logic step_last, seg_last, col_last, col_x;

  assign step_last = (cyc_q == PC_W'(PROG_CYCLES - 1));
  assign seg_last  = (seg_q == SEG_IW'(NSEG - 1));
  assign col_last  = (col_q == COL_W'(WIDTH - 1));
  assign col_x     = mask_q[col_q];

  always_comb begin
    case (state)
      ST_LOW:  phase = PH_LOW;
      ST_HIL:  phase = PH_HIL;
      ST_HIM:  phase = PH_HIM;
      default: phase = PH_NONE;
    endcase
    case (state)
      ST_S1:   vkind = VK_ONES;
      ST_S2:   vkind = VK_ZEROS;
      ST_CELL: vkind = col_x ? VK_NONE : VK_CELL;
      default: vkind = VK_NONE;
    endcase
  end

  twv_sel_gen #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_sel (
    .phase(phase), .seg(seg_q), .data(data_q), .mask(mask_q),
    .sel_left(sel_left), .sel_mid(sel_mid)
  );

  twv_key_gen #(.WIDTH(WIDTH)) u_key (
    .kind(vkind), .col(col_q), .data(data_q), .mask(mask_q),
    .key(srch_key), .wild(srch_wild)
  );

  assign busy       = (state != ST_IDLE);
  assign req_ready  = ~busy;
  assign done       = done_q;
  assign err        = err_q;
  assign arr_row    = row_q;
  assign prog_en    = (phase != PH_NONE);
  assign prog_lvl   = (phase == PH_HIL) || (phase == PH_HIM);
  assign en_clr_all = (state == ST_ENA);
  assign en_set     = (state == ST_ENA);
  assign srch_en    = (vkind != VK_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      row_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
      seg_q  <= '0;
      cyc_q  <= '0;
      col_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          row_q  <= req_row;
          data_q <= req_data;
          mask_q <= req_mask;
          seg_q  <= '0;
          cyc_q  <= '0;
          err_q  <= 1'b0;
          state  <= ST_LOW;
        end
        ST_LOW, ST_HIL, ST_HIM: begin
          if (step_last) begin
            cyc_q <= '0;
            if (seg_last) begin
              seg_q <= '0;
              state <= (state == ST_LOW) ? ST_HIL :
                       (state == ST_HIL) ? ST_HIM : ST_ENA;
            end else begin
              seg_q <= seg_q + 1'b1;
            end
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        ST_ENA: state <= ST_S1;
        ST_S1:  state <= ST_W1;
        ST_W1:  if (!srch_hit) begin
          err_q <= 1'b1; done_q <= 1'b1; state <= ST_IDLE;
        end else state <= ST_S2;
        ST_S2:  state <= ST_W2;
        ST_W2:  if (!srch_hit) begin
          err_q <= 1'b1; done_q <= 1'b1; state <= ST_IDLE;
        end else begin
          col_q <= '0;
          state <= ST_CELL;
        end
        ST_CELL: if (!col_x) state <= ST_CW;
        else if (col_last) begin
          done_q <= 1'b1; state <= ST_IDLE;
        end else col_q <= col_q + 1'b1;
        ST_CW: if (srch_hit) begin
          err_q <= 1'b1; done_q <= 1'b1; state <= ST_IDLE;
        end else if (col_last) begin
          done_q <= 1'b1; state <= ST_IDLE;
        end else begin
          col_q <= col_q + 1'b1;
          state <= ST_CELL;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: searching and wildcard lines stay quiet while programming
  assert_prog_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> (!srch_en && srch_wild == '0));
  // R4: element count per program step bounded by one segment
  assert_sel_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_left, sel_mid}) <= SEG_W);
  // R3: selects only with the strobe
  assert_sel_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |-> ((sel_left | sel_mid) == '0));
  // R3: no low step once high steps have started
  assert_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && prog_lvl) |=> !(prog_en && !prog_lvl));
  // R7: done is a single-cycle pulse with busy low
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7: error only appears with the end pulse
  assert_err_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
  // R8: an operation starts only from an offered request
  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/tb_trow_wv_seq.sv
module tb_trow_wv_seq;
  localparam int ROWS = 8;
  localparam int WIDTH = 16;
  localparam int SEG_W = 8;
  localparam int PROG_CYCLES = 3;
  localparam int ROW_W = 3;
  localparam int NVEC = 8;
  localparam int EXP_PROG = 3 * (WIDTH / SEG_W) * PROG_CYCLES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [WIDTH-1:0] req_data = '0, req_mask = '0;
  logic req_ready, busy, done, err, prog_en, prog_lvl, en_clr_all, en_set, srch_en;
  logic [ROW_W-1:0] arr_row;
  logic [WIDTH-1:0] sel_left, sel_mid, srch_key, srch_wild;
  logic hit;

  trow_wv_seq #(.ROWS(ROWS), .WIDTH(WIDTH), .SEG_W(SEG_W), .PROG_CYCLES(PROG_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_data(req_data), .req_mask(req_mask),
    .busy(busy), .done(done), .err(err), .arr_row(arr_row),
    .prog_en(prog_en), .prog_lvl(prog_lvl), .sel_left(sel_left), .sel_mid(sel_mid),
    .en_clr_all(en_clr_all), .en_set(en_set), .srch_en(srch_en),
    .srch_key(srch_key), .srch_wild(srch_wild), .srch_hit(hit)
  );

  // behavioural array with fault injection: 1 = left low lost on col 4, 2 = left high lost on col 9
  logic [WIDTH-1:0] mem_l [ROWS];
  logic [WIDTH-1:0] mem_m [ROWS];
  logic [ROWS-1:0]  en_v;
  int fault_mode = 0;

  function automatic logic row_match(input int r);
    for (int c = 0; c < WIDTH; c++)
      if (!srch_wild[c] && (srch_key[c] ? !mem_l[r][c] : !mem_m[r][c])) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        mem_l[r] <= '1;
        mem_m[r] <= '1;
      end
      en_v <= '0;
      hit  <= 1'b0;
    end else begin
      if (prog_en)
        for (int c = 0; c < WIDTH; c++) begin
          if (sel_left[c] && !(fault_mode == 1 && c == 4 && !prog_lvl)
              && !(fault_mode == 2 && c == 9 && prog_lvl))
            mem_l[arr_row][c] <= prog_lvl;
          if (sel_mid[c]) mem_m[arr_row][c] <= prog_lvl;
        end
      if (en_clr_all || en_set)
        en_v <= (en_clr_all ? '0 : en_v) | (en_set ? (ROWS'(1) << arr_row) : '0);
      if (srch_en) begin
        logic any;
        any = 1'b0;
        for (int r = 0; r < ROWS; r++) if (en_v[r] && row_match(r)) any = 1'b1;
        hit <= any;
      end
    end
  end

  // port monitor, sampled away from the active edge
  logic [WIDTH-1:0] acc_ll, acc_lm, acc_hl, acc_hm;
  int prog_cnt, srch_cnt, done_cnt, max_sel, stage;
  bit viol_quiet, viol_order;

  task automatic mon_clear();
    acc_ll = '0; acc_lm = '0; acc_hl = '0; acc_hm = '0;
    prog_cnt = 0; srch_cnt = 0; done_cnt = 0; max_sel = 0; stage = 0;
    viol_quiet = 0; viol_order = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (srch_en) srch_cnt++;
      if (prog_en) begin
        int s;
        prog_cnt++;
        if (srch_en || srch_wild != '0) viol_quiet = 1;
        if ($countones({sel_left, sel_mid}) > max_sel) max_sel = $countones({sel_left, sel_mid});
        s = stage;
        if (!prog_lvl) begin
          s = 1; acc_ll |= sel_left; acc_lm |= sel_mid;
        end else begin
          if (sel_mid != '0) s = 3; else if (sel_left != '0) s = 2;
          acc_hl |= sel_left; acc_hm |= sel_mid;
          if (sel_left != '0 && sel_mid != '0) viol_order = 1;
        end
        if (s < stage) viol_order = 1;
        stage = s;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start_req(input logic [ROW_W-1:0] r, input logic [WIDTH-1:0] d,
                           input logic [WIDTH-1:0] m);
    @(negedge clk);
    mon_clear();
    req_row = r; req_data = d; req_mask = m; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 2000 && !got; i++) begin
      if (done) got = 1;
      else @(negedge clk);
    end
  endtask

  localparam logic [ROW_W-1:0] V_ROW  [NVEC] = '{3'd2, 3'd5, 3'd0, 3'd7, 3'd3, 3'd1, 3'd3, 3'd6};
  localparam logic [WIDTH-1:0] V_DATA [NVEC] = '{16'hA5C3, 16'h0F0F, 16'h0000, 16'hFFFF,
                                                 16'h0000, 16'h0000, 16'hFFFF, 16'h8001};
  localparam logic [WIDTH-1:0] V_MASK [NVEC] = '{16'h0000, 16'h00FF, 16'hFFFF, 16'h0000,
                                                 16'h0000, 16'h0000, 16'h0000, 16'h7FFE};
  localparam int V_FAULT [NVEC] = '{0, 0, 0, 0, 0, 1, 2, 0};
  localparam bit V_ERR   [NVEC] = '{0, 0, 0, 0, 0, 1, 1, 0};

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit got;
    logic [WIDTH-1:0] snap_l, snap_m;
    mon_clear();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(req_ready && !busy && !done && !err && !prog_en && !srch_en && !en_clr_all && !en_set,
        "R9", "reset outputs", {busy, done, err, prog_en, srch_en, req_ready}, 32'h1);

    for (int v = 0; v < NVEC; v++) begin
      logic [WIDTH-1:0] d, m;
      d = V_DATA[v]; m = V_MASK[v];
      fault_mode = V_FAULT[v];
      start_req(V_ROW[v], d, m);
      chk(busy && !err, "R7", "err cleared on accept", {busy, err}, 32'h2);
      wait_done(got);
      chk(got, "R7", "done seen", got, 1);
      chk(err == V_ERR[v], V_FAULT[v] == 1 ? "R6" : "R5", "verify outcome", err, V_ERR[v]);
      chk(!busy, "R7", "busy low with done", busy, 0);
      chk(en_v == (ROWS'(1) << V_ROW[v]), "R5", "only written row enabled", en_v, ROWS'(1) << V_ROW[v]);
      chk(!viol_quiet, "R2", "quiet during program", viol_quiet, 0);
      chk(!viol_order && acc_ll == (~d & ~m) && acc_lm == (d & ~m), "R3", "low step selects",
          {acc_ll, acc_lm}, {~d & ~m, d & ~m});
      chk(!viol_order && acc_hl == (d | m) && acc_hm == (~d | m), "R3", "high step selects",
          {acc_hl, acc_hm}, {d | m, ~d | m});
      chk(prog_cnt == EXP_PROG && max_sel <= SEG_W, "R4", "strobe cycles", prog_cnt, EXP_PROG);
      if (!V_ERR[v]) begin
        chk(mem_l[V_ROW[v]] == (d | m) && mem_m[V_ROW[v]] == (~d | m), "R1", "cell encoding",
            {mem_l[V_ROW[v]], mem_m[V_ROW[v]]}, {d | m, ~d | m});
        chk(srch_cnt == 2 + WIDTH - $countones(m), "R6", "search count", srch_cnt,
            2 + WIDTH - $countones(m));
      end
      @(negedge clk);
      chk(!done, "R7", "done one cycle", done, 0);
      if (V_ERR[v]) begin
        repeat (3) @(negedge clk);
        chk(err, "R7", "err held", err, 1);
      end
      chk(done_cnt == 1, "R7", "single done", done_cnt, 1);
    end

    // R8: request offered while busy is ignored
    fault_mode = 0;
    snap_l = mem_l[6]; snap_m = mem_m[6];
    start_req(3'd4, 16'h00F0, 16'h0000);
    repeat (3) @(negedge clk);
    chk(!req_ready && busy, "R8", "ready low while busy", req_ready, 0);
    req_row = 3'd6; req_data = 16'h0000; req_mask = 16'h0000; req_valid = 1'b1;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    wait_done(got);
    chk(got && !err, "R8", "first request completes", {got, err}, 32'h2);
    repeat (3) @(negedge clk);
    chk(!busy && done_cnt == 1, "R8", "no second operation", {busy, done_cnt[7:0]}, 32'h1);
    chk(mem_l[6] == snap_l && mem_m[6] == snap_m, "R8", "busy-time request left row untouched",
        {mem_l[6], mem_m[6]}, {snap_l, snap_m});
    chk(mem_l[4] == 16'h00F0 && mem_m[4] == 16'hFF0F, "R1", "row 4 encoding",
        {mem_l[4], mem_m[4]}, {16'h00F0, 16'hFF0F});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule